// File: doc/BRIEF.md
# Pin Interrupt Controller

This block monitors a group of general-purpose input pins and turns activity on them into interrupt requests. There is one interrupt line per channel. A channel either latches edges or follows a level. Edge channels can fire on a rising edge, a falling edge or both. Level channels fire while the pin is high or while it is low. Each pin first passes through a two-flop synchroniser. The synchronised value is then compared with its value one clock earlier to find edges.

Software controls the block through a small 32-bit register bus, with one access per cycle and read data returned one cycle after the request. Enable bits are never written directly. Each enable group has one write port that sets bits and a separate write port that clears them, so two drivers can work on different channels without a read-modify-write. In level mode the falling-enable bit selects the active level. Edge status is latched and cleared by writing 1. Level status is live.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every channel is in edge mode, all rising and falling enables read 0, all status bits read 0 and every interrupt output is low.
- R2: The mode word at byte offset 0x000 is read/write. Bit n set to 1 puts channel n in level mode, and 0 puts it in edge mode.
- R3: Writing at 0x008 sets every rising/level enable bit whose data bit is 1, and writing at 0x00C clears those bits. Data bits that are 0 leave their enables unchanged. A read at either offset returns the rising/level enable word.
- R4: Writing at 0x014 sets the falling enable bits marked by 1s, and writing at 0x018 clears them. Bits written as 0 change nothing, and the rising/level enables are not touched. A read at either offset returns the falling enable word.
- R5: A pin change reaches a status bit and an interrupt output at the third rising clock edge after the edge that first samples it. There is no change at the first or the second edge.
- R6: In edge mode, an edge in either direction is latched as status even when that direction is disabled, and status reads as 1. The interrupt output is high only when a latched edge has its direction enabled. Enabling that direction later raises the output on the next cycle.
- R7: In edge mode, with both the rising and falling enables set, each edge in either direction raises the channel's interrupt.
- R8: The status word is at 0x024. Writing 1 to a bit clears that edge channel's latched edges, and 0 bits keep their state. An edge detected in the same cycle as the clear wins.
- R9: In level mode, status and interrupt equal the rising/level enable ANDed with (pin equal to the falling enable bit), so falling enable 1 means active high and 0 means active low. Nothing is latched, and writes to the status word have no effect.
- R10: Clearing both enable words with all 1s, writing 0 to the mode word and writing all 1s to the status word leaves every interrupt output low and status reading 0.
- R11: Each channel drives only its own interrupt bit. Activity on one channel leaves every other output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_CH | Asynchronous input pins, one per channel |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_ren |
| irq_o | output | NUM_CH | Registered interrupt output per channel |

## Verification
The assertions assume a bus that issues a write or a read, never both in the same cycle, with a stable address and data for that cycle. They also assume each pin level is held for at least three clocks, so every change is seen as exactly one edge. The stimulus changes bus signals and pins only just after a falling clock edge. It holds every pin level well beyond the synchroniser window and issues one access at a time. The edge-latch and clear checks therefore watch single, well-separated events.

// File: rtl/pint_pkg.sv
package pint_pkg;
  localparam int DATA_W = 32;

  localparam int OFS_MODE  = 'h000;
  localparam int OFS_RSET  = 'h008;
  localparam int OFS_RCLR  = 'h00C;
  localparam int OFS_FSET  = 'h014;
  localparam int OFS_FCLR  = 'h018;
  localparam int OFS_STAT  = 'h024;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MODE,
    SEL_RSET,
    SEL_RCLR,
    SEL_FSET,
    SEL_FCLR,
    SEL_STAT
  } reg_sel_e;
endpackage

// File: rtl/pint_sync.sv
module pint_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pint_channel.sv
module pint_channel (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic mode,
  input  logic en_r,
  input  logic en_f,
  input  logic clr,
  output logic stat_o,
  output logic irq_o
);
  logic prev_q;
  logic pend_r_q, pend_f_q;
  logic lvl_q;
  logic irq_q;
  logic rise, fall;
  logic pend_r_n, pend_f_n;
  logic lvl_n;

  assign rise = pin_s & ~prev_q;
  assign fall = ~pin_s & prev_q;

  always_comb begin
    pend_r_n = rise | (pend_r_q & ~clr);
    pend_f_n = fall | (pend_f_q & ~clr);
    lvl_n    = en_r & (pin_s == en_f);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      pend_r_q <= 1'b0;
      pend_f_q <= 1'b0;
      lvl_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (mode) begin
        pend_r_q <= 1'b0;
        pend_f_q <= 1'b0;
        lvl_q    <= lvl_n;
        irq_q    <= lvl_n;
      end else begin
        pend_r_q <= pend_r_n;
        pend_f_q <= pend_f_n;
        lvl_q    <= 1'b0;
        irq_q    <= (pend_r_n & en_r) | (pend_f_n & en_f);
      end
    end
  end

  assign stat_o = mode ? lvl_q : (pend_r_q | pend_f_q);
  assign irq_o  = irq_q;

  assert_level_no_latch_R9: assert property (@(posedge clk) disable iff (rst)
    mode |=> (!pend_r_q && !pend_f_q));

  assert_edge_latch_R6: assert property (@(posedge clk) disable iff (rst)
    (!mode && rise) |=> pend_r_q);

  assert_fall_latch_R6: assert property (@(posedge clk) disable iff (rst)
    (!mode && fall) |=> pend_f_q);

  assert_status_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (!mode && clr && !rise && !fall) |=> (!pend_r_q && !pend_f_q));

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(en_r | en_f));
endmodule

// File: rtl/pint_regs.sv
module pint_regs
  import pint_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wen,
  input  logic              ren,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_CH-1:0] stat_i,
  output logic [NUM_CH-1:0] mode_o,
  output logic [NUM_CH-1:0] en_r_o,
  output logic [NUM_CH-1:0] en_f_o,
  output logic [NUM_CH-1:0] stat_clr_o
);
  reg_sel_e          sel;
  logic [NUM_CH-1:0] wd;
  logic [NUM_CH-1:0] mode_q, en_r_q, en_f_q;
  logic [DATA_W-1:0] rdata_q;

  assign wd = wdata[NUM_CH-1:0];

  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OFS_MODE)) sel = SEL_MODE;
    else if (addr == ADDR_W'(OFS_RSET)) sel = SEL_RSET;
    else if (addr == ADDR_W'(OFS_RCLR)) sel = SEL_RCLR;
    else if (addr == ADDR_W'(OFS_FSET)) sel = SEL_FSET;
    else if (addr == ADDR_W'(OFS_FCLR)) sel = SEL_FCLR;
    else if (addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      en_r_q <= '0;
      en_f_q <= '0;
    end else if (wen) begin
      case (sel)
        SEL_MODE: mode_q <= wd;
        SEL_RSET: en_r_q <= en_r_q | wd;
        SEL_RCLR: en_r_q <= en_r_q & ~wd;
        SEL_FSET: en_f_q <= en_f_q | wd;
        SEL_FCLR: en_f_q <= en_f_q & ~wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (ren) begin
      case (sel)
        SEL_MODE:           rdata_q <= DATA_W'(mode_q);
        SEL_RSET, SEL_RCLR: rdata_q <= DATA_W'(en_r_q);
        SEL_FSET, SEL_FCLR: rdata_q <= DATA_W'(en_f_q);
        SEL_STAT:           rdata_q <= DATA_W'(stat_i);
        default:            rdata_q <= '0;
      endcase
    end
  end

  assign stat_clr_o = (wen && sel == SEL_STAT) ? wd : '0;
  assign mode_o     = mode_q;
  assign en_r_o     = en_r_q;
  assign en_f_o     = en_f_q;
  assign rdata      = rdata_q;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode_q == '0 && en_r_q == '0 && en_f_q == '0));

  assert_rset_R3: assert property (@(posedge clk) disable iff (rst)
    (wen && sel == SEL_RSET) |=> ((en_r_q & $past(wd)) == $past(wd)));

  assert_rclr_R3: assert property (@(posedge clk) disable iff (rst)
    (wen && sel == SEL_RCLR) |=> ((en_r_q & $past(wd)) == '0));

  assert_rhold_R3: assert property (@(posedge clk) disable iff (rst)
    !(wen && (sel == SEL_RSET || sel == SEL_RCLR)) |=> $stable(en_r_q));

  assert_fset_R4: assert property (@(posedge clk) disable iff (rst)
    (wen && sel == SEL_FSET) |=> ((en_f_q & $past(wd)) == $past(wd)));

  assert_fclr_R4: assert property (@(posedge clk) disable iff (rst)
    (wen && sel == SEL_FCLR) |=> ((en_f_q & $past(wd)) == '0));

  assert_fhold_R4: assert property (@(posedge clk) disable iff (rst)
    !(wen && (sel == SEL_FSET || sel == SEL_FCLR)) |=> $stable(en_f_q));
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pint_pkg::*;
#(
  parameter int NUM_CH      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] pin_s;
  logic [NUM_CH-1:0] mode, en_r, en_f, stat_clr, stat;
  logic [NUM_CH-1:0] irq;

  pint_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pin_i),
    .dout(pin_s)
  );

  pint_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wen       (bus_wen),
    .ren       (bus_ren),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .stat_i    (stat),
    .mode_o    (mode),
    .en_r_o    (en_r),
    .en_f_o    (en_f),
    .stat_clr_o(stat_clr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pint_channel u_ch (
      .clk   (clk),
      .rst   (rst),
      .pin_s (pin_s[c]),
      .mode  (mode[c]),
      .en_r  (en_r[c]),
      .en_f  (en_f[c]),
      .clr   (stat_clr[c]),
      .stat_o(stat[c]),
      .irq_o (irq[c])
    );
  end

  assign irq_o = irq;

  assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(en_r) == '0 && $past(en_f) == '0) |-> (irq_o == '0));
endmodule

// File: tb/pin_irq_ctrl_tb.sv
module pin_irq_ctrl_tb;
  localparam int NC = 32;

  logic        clk = 1'b0;
  logic        rst;
  logic [NC-1:0] pin;
  logic        wen, ren;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [NC-1:0] irq;

  always #4 clk = ~clk;

  pin_irq_ctrl #(.NUM_CH(NC), .ADDR_W(8), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .pin_i(pin), .bus_wen(wen), .bus_ren(ren),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  typedef struct {
    bit          is_rd;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  item_t       mon_it;
  event        chk_ev;
  logic [31:0] rd_val;
  logic [31:0] obs;
  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 0;

  always @(chk_ev) begin
    while (sb_q.size() > 0) begin
      mon_it = sb_q.pop_front();
      obs = mon_it.is_rd ? rd_val : 32'(irq);
      n_run++;
      if (obs !== mon_it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", mon_it.tag, obs, mon_it.exp);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wen = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic expect_irq(input logic [31:0] e, input string tag);
    item_t it;
    it.is_rd = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> chk_ev;
    #0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    ren = 1'b1; addr = a;
    @(negedge clk);
    ren = 1'b0;
    rd_val = rdata;
    it.is_rd = 1'b1; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> chk_ev;
    #0;
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(negedge clk);
    pin[idx] = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pin = '0; wen = 1'b0; ren = 1'b0; addr = '0; wdata = '0;
    wait_n(4);
    rst = 1'b0;
    wait_n(1);

    // R1 reset state
    expect_irq(32'h0, "R1 irq");
    expect_rd(8'h00, 32'h0, "R1 mode");
    expect_rd(8'h08, 32'h0, "R1 rise en");
    expect_rd(8'h14, 32'h0, "R1 fall en");
    expect_rd(8'h24, 32'h0, "R1 status");

    // R2 mode word
    bus_wr(8'h00, 32'hA5);
    expect_rd(8'h00, 32'hA5, "R2 mode readback");
    bus_wr(8'h00, 32'h0);

    // R3 rising/level enables
    bus_wr(8'h08, 32'h0F);
    expect_rd(8'h0C, 32'h0F, "R3 set");
    bus_wr(8'h0C, 32'h03);
    expect_rd(8'h08, 32'h0C, "R3 clear");
    bus_wr(8'h08, 32'h0);
    expect_rd(8'h08, 32'h0C, "R3 zero write");

    // R4 falling enables
    bus_wr(8'h14, 32'hF0);
    expect_rd(8'h18, 32'hF0, "R4 set");
    bus_wr(8'h18, 32'h30);
    expect_rd(8'h14, 32'hC0, "R4 clear");
    bus_wr(8'h18, 32'h0);
    expect_rd(8'h14, 32'hC0, "R4 zero write");
    expect_rd(8'h08, 32'h0C, "R4 rise untouched");
    bus_wr(8'h0C, 32'hFFFF_FFFF);
    bus_wr(8'h18, 32'hFFFF_FFFF);
    expect_rd(8'h08, 32'h0, "R3 clear all");

    // R5 latency
    bus_wr(8'h08, 32'h1);
    set_pin(0, 1'b1);
    wait_n(2);
    expect_irq(32'h0, "R5 before third edge");
    wait_n(1);
    expect_irq(32'h1, "R5 at third edge");
    expect_rd(8'h24, 32'h1, "R8 status set");

    // R8 write-one-to-clear
    bus_wr(8'h24, 32'h0);
    wait_n(2);
    expect_irq(32'h1, "R8 zero bits keep");
    bus_wr(8'h24, 32'h1);
    wait_n(2);
    expect_irq(32'h0, "R8 cleared");
    expect_rd(8'h24, 32'h0, "R8 status clear");

    // R6 disabled direction latches
    set_pin(0, 1'b0);
    wait_n(4);
    expect_irq(32'h0, "R6 fall disabled");
    expect_rd(8'h24, 32'h1, "R6 fall latched");
    bus_wr(8'h14, 32'h1);
    wait_n(2);
    expect_irq(32'h1, "R6 late enable fall");
    bus_wr(8'h0C, 32'h1);
    bus_wr(8'h18, 32'h1);
    bus_wr(8'h24, 32'h1);
    set_pin(0, 1'b1);
    wait_n(4);
    expect_irq(32'h0, "R6 fully disabled");
    bus_wr(8'h08, 32'h1);
    wait_n(2);
    expect_irq(32'h1, "R6 re-enable pending");
    bus_wr(8'h0C, 32'h1);
    bus_wr(8'h24, 32'h1);

    // R7 both edges
    bus_wr(8'h08, 32'h2);
    bus_wr(8'h14, 32'h2);
    set_pin(1, 1'b1);
    wait_n(4);
    expect_irq(32'h2, "R7 rising");
    bus_wr(8'h24, 32'h2);
    wait_n(2);
    expect_irq(32'h0, "R7 cleared");
    set_pin(1, 1'b0);
    wait_n(4);
    expect_irq(32'h2, "R7 falling");
    bus_wr(8'h24, 32'h2);

    // R11 independence
    bus_wr(8'h08, 32'h8);
    set_pin(3, 1'b1);
    wait_n(4);
    expect_irq(32'h8, "R11 only ch3");
    bus_wr(8'h24, 32'h8);
    wait_n(2);
    expect_irq(32'h0, "R11 cleared");

    // R9 level mode
    bus_wr(8'h00, 32'h4);
    bus_wr(8'h08, 32'h4);
    bus_wr(8'h14, 32'h4);
    set_pin(2, 1'b1);
    wait_n(2);
    expect_irq(32'h0, "R9 before third edge");
    wait_n(1);
    expect_irq(32'h4, "R9 active high");
    bus_wr(8'h24, 32'h4);
    wait_n(2);
    expect_irq(32'h4, "R9 status write ignored");
    expect_rd(8'h24, 32'h4, "R9 live status");
    set_pin(2, 1'b0);
    wait_n(4);
    expect_irq(32'h0, "R9 no latch");
    bus_wr(8'h18, 32'h4);
    wait_n(2);
    expect_irq(32'h4, "R9 active low");
    bus_wr(8'h0C, 32'h4);
    wait_n(2);
    expect_irq(32'h0, "R9 gated off");

    // R10 quiet state
    set_pin(1, 1'b1);
    wait_n(4);
    expect_irq(32'h2, "R10 pending ch1");
    bus_wr(8'h08, 32'h4);
    wait_n(2);
    expect_irq(32'h6, "R10 pending ch1 ch2");
    bus_wr(8'h0C, 32'hFFFF_FFFF);
    bus_wr(8'h18, 32'hFFFF_FFFF);
    bus_wr(8'h00, 32'h0);
    bus_wr(8'h24, 32'hFFFF_FFFF);
    wait_n(2);
    expect_irq(32'h0, "R10 irq quiet");
    expect_rd(8'h24, 32'h0, "R10 status quiet");
    expect_rd(8'h00, 32'h0, "R10 mode edge");

    wait_n(2);
    #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule